// File: doc/BRIEF.md
# Multi-PHY Polling Receive Arbiter

This block sits on the receive side of an ATM layer device. It shares one 8-bit cell bus among up to eight multi-port physical layer devices, each holding four logical ports, so 32 ports in all. It steps a 2-bit port address across the devices and watches the cell-available line of the device under test. Each device has its own cell-available line, and an internal multiplexer keyed by the decoded device number picks the one that matters. When a port reports a cell, the block drives that port's 2-bit address and raises exactly one device's read-enable, so only that device drives the shared data, parity and start-of-cell lines.

The block then reads exactly one 53-byte cell. It hands the bytes downstream with first/last markers and the 5-bit port number. It checks start-of-cell framing and discards a badly framed cell by suppressing its bytes and raising an abort pulse. After every cell it keeps the bus idle for a minimum number of cycles. Polling is round-robin and resumes at the port after the one just served.

Top module: `mpoll_arb`

## Requirements
- R1: The port number is device index times four plus the 2-bit port address. `cell_port_o` carries the number of the port whose cell is being delivered.
- R2: At most one bit of `phy_rd_en_o` is high at any time. Bit d enables device d, and active means high.
- R3: While polling, the block samples the cell-available line of the polled port's device one clock after that port's address was presented. It serves only a port that reported a cell.
- R4: After reset, polling starts at port 0. After a cell is served, polling resumes at the next higher port number, wrapping from 31 to 0, so available ports are served in ascending cyclic order.
- R5: A device whose cell-available line stays low, for example because it is absent, is never enabled.
- R6: A transfer holds one device's read-enable high for exactly 53 consecutive cycles. The port address stays unchanged during those cycles.
- R7: At least 3 cycles with no read-enable separate consecutive transfers.
- R8: The byte on the shared bus is taken one cycle after each read-enable cycle. A cell is delivered in arrival order with data and parity unchanged, `cell_sop_o` on byte 0 and `cell_eop_o` on byte 52.
- R9: If start-of-cell is low on byte 0, none of that cell's bytes are delivered and `cell_abort_o` pulses once.
- R10: If start-of-cell is high on any byte after byte 0, the bytes before it are delivered, `cell_abort_o` pulses once on that byte, the rest of the cell is suppressed and no `cell_eop_o` is given.
- R11: During reset, `phy_rd_en_o`, `cell_valid_o` and `cell_abort_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phy_ca_i | input | 8 | Cell-available line of each device for the address it last saw |
| phy_addr_o | output | 2 | Port address shared by all devices |
| phy_rd_en_o | output | 8 | One read-enable per device, active high |
| phy_data_i | input | 8 | Shared receive data byte |
| phy_par_i | input | 1 | Shared receive parity |
| phy_soc_i | input | 1 | Shared start-of-cell |
| cell_valid_o | output | 1 | Delivered byte is valid |
| cell_data_o | output | 8 | Delivered byte |
| cell_par_o | output | 1 | Parity of the delivered byte |
| cell_sop_o | output | 1 | Delivered byte is byte 0 of the cell |
| cell_eop_o | output | 1 | Delivered byte is byte 52 of the cell |
| cell_abort_o | output | 1 | The current cell is discarded due to framing |
| cell_port_o | output | 5 | Port number of the delivered cell |

## Verification
The assertions watch the bus handshake on every cycle. They check that at most one read-enable is high, that the address and enable stay put within a burst, that every burst is exactly 53 cycles long with at least 3 idle cycles between bursts, and that abort and valid never coincide. Only the bench's scenarios can show the rest, using a device model that answers polls one cycle late: the round-robin order, the port chosen first after reset, the skipping of absent devices, byte content and port numbering, and the two framing-error outcomes.

// File: rtl/mpoll_pkg.sv
package mpoll_pkg;

    localparam int BYTE_W        = 8;
    localparam int DEF_DEV_N     = 8;
    localparam int DEF_PER_DEV   = 4;
    localparam int DEF_CELL_LEN  = 53;
    localparam int DEF_GAP_MIN   = 3;

    typedef enum logic [1:0] {
        ARB_POLL = 2'd0,
        ARB_XFER = 2'd1,
        ARB_GAP  = 2'd2
    } arb_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              par;
        logic              soc;
    } bus_word_t;

    function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/mpoll_scan.sv
module mpoll_scan #(
    parameter int DEV_N  = 8,
    parameter int SUB_W  = 2,
    parameter int PORT_W = 5,
    parameter int TOTAL  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [DEV_N-1:0]  ca_i,
    output logic [PORT_W-1:0] poll_ptr_o,
    output logic              hit_o,
    output logic [PORT_W-1:0] hit_ptr_o
);
    logic [PORT_W-1:0] poll_q;
    logic [PORT_W-1:0] samp_q;
    logic              samp_vld_q;
    logic              ca_sel;

    function automatic logic [PORT_W-1:0] step(input logic [PORT_W-1:0] p);
        return (p == PORT_W'(TOTAL - 1)) ? '0 : p + 1'b1;
    endfunction

    // status of the device addressed one cycle earlier
    assign ca_sel = ca_i[samp_q[PORT_W-1:SUB_W]];
    assign hit_o  = run_i && samp_vld_q && ca_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_q     <= '0;
            samp_q     <= '0;
            samp_vld_q <= 1'b0;
        end else if (!run_i) begin
            samp_vld_q <= 1'b0;
        end else if (hit_o) begin
            poll_q     <= step(samp_q);
            samp_vld_q <= 1'b0;
        end else begin
            samp_q     <= poll_q;
            samp_vld_q <= 1'b1;
            poll_q     <= step(poll_q);
        end
    end

    assign poll_ptr_o = poll_q;
    assign hit_ptr_o  = samp_q;
endmodule

// File: rtl/mpoll_rden_dec.sv
module mpoll_rden_dec #(
    parameter int DEV_N = 8,
    parameter int DEV_W = 3
) (
    input  logic             en_i,
    input  logic [DEV_W-1:0] dev_i,
    output logic [DEV_N-1:0] rd_en_o
);
    for (genvar d = 0; d < DEV_N; d++) begin : g_dev
        assign rd_en_o[d] = en_i && (dev_i == DEV_W'(d));
    end
endmodule

// File: rtl/mpoll_capture.sv
module mpoll_capture
    import mpoll_pkg::*;
#(
    parameter int PORT_W   = 5,
    parameter int CELL_LEN = 53,
    parameter int CNT_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [PORT_W-1:0] port_i,
    input  bus_word_t         bus_i,
    output logic              valid_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              par_o,
    output logic              sop_o,
    output logic              eop_o,
    output logic              abort_o,
    output logic [PORT_W-1:0] port_o
);
    logic              cap_vld_q;
    logic              cap_first_q;
    logic              cap_last_q;
    logic [PORT_W-1:0] cap_port_q;
    logic              drop_q;
    logic              drop_eff;
    logic              err_now;
    logic              keep;

    assign drop_eff = cap_first_q ? 1'b0 : drop_q;
    assign err_now  = cap_vld_q && (cap_first_q ? !bus_i.soc : bus_i.soc);
    assign keep     = cap_vld_q && !err_now && !drop_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld_q   <= 1'b0;
            cap_first_q <= 1'b0;
            cap_last_q  <= 1'b0;
            cap_port_q  <= '0;
            drop_q      <= 1'b0;
            valid_o     <= 1'b0;
            data_o      <= '0;
            par_o       <= 1'b0;
            sop_o       <= 1'b0;
            eop_o       <= 1'b0;
            abort_o     <= 1'b0;
            port_o      <= '0;
        end else begin
            cap_vld_q   <= xfer_i;
            cap_first_q <= xfer_i && (cnt_i == '0);
            cap_last_q  <= xfer_i && (cnt_i == CNT_W'(CELL_LEN - 1));
            cap_port_q  <= port_i;
            if (cap_vld_q) begin
                drop_q <= drop_eff || err_now;
            end
            valid_o <= keep;
            data_o  <= bus_i.data;
            par_o   <= bus_i.par;
            sop_o   <= keep && cap_first_q;
            eop_o   <= keep && cap_last_q;
            abort_o <= err_now && !drop_eff;
            port_o  <= cap_port_q;
        end
    end
endmodule

// File: rtl/mpoll_arb.sv
module mpoll_arb
    import mpoll_pkg::*;
#(
    parameter int DEV_N         = DEF_DEV_N,
    parameter int PORTS_PER_DEV = DEF_PER_DEV,
    parameter int CELL_LEN      = DEF_CELL_LEN,
    parameter int GAP_MIN       = DEF_GAP_MIN,
    localparam int SUB_W        = $clog2(PORTS_PER_DEV),
    localparam int DEV_W        = $clog2(DEV_N),
    localparam int PORT_W       = DEV_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEV_N-1:0]  phy_ca_i,
    output logic [SUB_W-1:0]  phy_addr_o,
    output logic [DEV_N-1:0]  phy_rd_en_o,
    input  logic [BYTE_W-1:0] phy_data_i,
    input  logic              phy_par_i,
    input  logic              phy_soc_i,
    output logic              cell_valid_o,
    output logic [BYTE_W-1:0] cell_data_o,
    output logic              cell_par_o,
    output logic              cell_sop_o,
    output logic              cell_eop_o,
    output logic              cell_abort_o,
    output logic [PORT_W-1:0] cell_port_o
);
    localparam int TOTAL = DEV_N * PORTS_PER_DEV;
    localparam int CNT_W = cnt_width(CELL_LEN, GAP_MIN);

    arb_state_t        st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PORT_W-1:0] srv_q;
    logic [PORT_W-1:0] poll_ptr;
    logic [PORT_W-1:0] hit_ptr;
    logic              hit;
    logic              xfer;
    bus_word_t         bus_w;

    assign xfer = (st_q == ARB_XFER);

    mpoll_scan #(
        .DEV_N (DEV_N),
        .SUB_W (SUB_W),
        .PORT_W(PORT_W),
        .TOTAL (TOTAL)
    ) scan_i (
        .clk       (clk),
        .rst       (rst),
        .run_i     (st_q == ARB_POLL),
        .ca_i      (phy_ca_i),
        .poll_ptr_o(poll_ptr),
        .hit_o     (hit),
        .hit_ptr_o (hit_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ARB_POLL;
            cnt_q <= '0;
            srv_q <= '0;
        end else begin
            unique case (st_q)
                ARB_POLL: begin
                    if (hit) begin
                        st_q  <= ARB_XFER;
                        srv_q <= hit_ptr;
                        cnt_q <= '0;
                    end
                end
                ARB_XFER: begin
                    if (cnt_q == CNT_W'(CELL_LEN - 1)) begin
                        st_q  <= ARB_GAP;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ARB_GAP: begin
                    if (cnt_q == CNT_W'(GAP_MIN - 1)) begin
                        st_q  <= ARB_POLL;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= ARB_POLL;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign phy_addr_o = xfer ? srv_q[SUB_W-1:0] : poll_ptr[SUB_W-1:0];

    mpoll_rden_dec #(
        .DEV_N(DEV_N),
        .DEV_W(DEV_W)
    ) dec_i (
        .en_i   (xfer),
        .dev_i  (srv_q[PORT_W-1:SUB_W]),
        .rd_en_o(phy_rd_en_o)
    );

    assign bus_w = '{data: phy_data_i, par: phy_par_i, soc: phy_soc_i};

    mpoll_capture #(
        .PORT_W  (PORT_W),
        .CELL_LEN(CELL_LEN),
        .CNT_W   (CNT_W)
    ) cap_i (
        .clk    (clk),
        .rst    (rst),
        .xfer_i (xfer),
        .cnt_i  (cnt_q),
        .port_i (srv_q),
        .bus_i  (bus_w),
        .valid_o(cell_valid_o),
        .data_o (cell_data_o),
        .par_o  (cell_par_o),
        .sop_o  (cell_sop_o),
        .eop_o  (cell_eop_o),
        .abort_o(cell_abort_o),
        .port_o (cell_port_o)
    );
endmodule

// File: rtl/mpoll_arb_chk.sv
module mpoll_arb_chk #(
    parameter int DEV_N    = 8,
    parameter int SUB_W    = 2,
    parameter int PORT_W   = 5,
    parameter int CELL_LEN = 53,
    parameter int GAP_MIN  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [DEV_N-1:0]  phy_rd_en_o,
    input logic [SUB_W-1:0]  phy_addr_o,
    input logic              cell_valid_o,
    input logic              cell_abort_o,
    input logic              cell_sop_o,
    input logic [PORT_W-1:0] cell_port_o
);
    logic [15:0] run_len;
    logic [7:0]  idle_len;
    logic        seen_burst;
    logic        rd_any;

    assign rd_any = |phy_rd_en_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len    <= '0;
            idle_len   <= '0;
            seen_burst <= 1'b0;
        end else if (rd_any) begin
            run_len  <= run_len + 1'b1;
            idle_len <= '0;
        end else begin
            if (run_len != '0) seen_burst <= 1'b1;
            run_len <= '0;
            if (idle_len != 8'hFF) idle_len <= idle_len + 1'b1;
        end
    end

    a_r2_one_enable: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phy_rd_en_o));

    a_r6_burst_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_any && $past(rd_any)) |-> ($stable(phy_addr_o) && $stable(phy_rd_en_o)));

    a_r6_burst_len: assert property (@(posedge clk) disable iff (rst)
        (!rd_any && (run_len != '0)) |-> (run_len == 16'(CELL_LEN)));

    a_r7_idle_gap: assert property (@(posedge clk) disable iff (rst)
        (rd_any && (run_len == '0) && seen_burst) |-> (idle_len >= 8'(GAP_MIN)));

    a_r10_abort_excl: assert property (@(posedge clk) disable iff (rst)
        !(cell_valid_o && cell_abort_o));

    a_r1_port_steady: assert property (@(posedge clk) disable iff (rst)
        (cell_valid_o && !cell_sop_o) |-> $stable(cell_port_o));
endmodule

bind mpoll_arb mpoll_arb_chk #(
    .DEV_N   (DEV_N),
    .SUB_W   (SUB_W),
    .PORT_W  (PORT_W),
    .CELL_LEN(CELL_LEN),
    .GAP_MIN (GAP_MIN)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .phy_rd_en_o (phy_rd_en_o),
    .phy_addr_o  (phy_addr_o),
    .cell_valid_o(cell_valid_o),
    .cell_abort_o(cell_abort_o),
    .cell_sop_o  (cell_sop_o),
    .cell_port_o (cell_port_o)
);

// File: tb/mpoll_arb_tb_top.sv
`timescale 1ns/1ps
module mpoll_arb_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ca = '0;
    logic [1:0] phy_addr;
    logic [7:0] phy_rd_en;
    logic [7:0] bus_d = '0;
    logic       bus_p = 1'b0;
    logic       bus_s = 1'b0;
    logic       cell_valid, cell_par, cell_sop, cell_eop, cell_abort;
    logic [7:0] cell_data;
    logic [4:0] cell_port;

    always #2 clk = ~clk;

    mpoll_arb dut_i (
        .clk(clk), .rst(rst), .phy_ca_i(ca), .phy_addr_o(phy_addr),
        .phy_rd_en_o(phy_rd_en), .phy_data_i(bus_d), .phy_par_i(bus_p),
        .phy_soc_i(bus_s), .cell_valid_o(cell_valid), .cell_data_o(cell_data),
        .cell_par_o(cell_par), .cell_sop_o(cell_sop), .cell_eop_o(cell_eop),
        .cell_abort_o(cell_abort), .cell_port_o(cell_port)
    );

    // {available ports, present devices, expected cells}
    localparam logic [47:0] VEC [5] = '{
        {32'h0000_0001, 8'hFF, 8'd1},
        {32'h8000_0010, 8'hFF, 8'd2},
        {32'h0000_F00F, 8'hFF, 8'd8},
        {32'hFFFF_FFFF, 8'h0F, 8'd16},
        {32'h1248_8421, 8'hAA, 8'd4}
    };

    int total = 0;
    int bad = 0;

    logic [31:0] avail = '0;
    logic [7:0]  present = 8'hFF;
    int err_port = -1;
    int err_mode = 0;
    int last_served = 31;
    int first_port = -1;
    bit first_of_row = 0;
    int served_cnt = 0;
    int cur_port = 0;
    int order_bad = 0, unexp_bad = 0;
    int cell_bytes = 0, cell_aborts = 0, cell_eops = 0, eop_total = 0;
    int data_bad = 0, port_bad = 0, par_bad = 0;
    int burst_bad = 0, onehot_bad = 0, gap_min = 1000;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int p, input int i);
        return 8'((p * 7 + i * 3) & 255);
    endfunction

    function automatic logic soc_of(input int p, input int i);
        if (p == err_port && err_mode == 1) return 1'b0;
        if (p == err_port && err_mode == 2) return (i == 0) || (i == 20);
        return i == 0;
    endfunction

    function automatic int dev_of(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic int rr_next(input int from);
        for (int i = 1; i <= 32; i++) begin
            int q;
            q = (from + i) % 32;
            if (avail[q] && present[q / 4]) return q;
        end
        return -1;
    endfunction

    // Device model and output monitor, both away from the rising edge
    initial begin
        logic [1:0] last_addr;
        logic [7:0] last_rd;
        int idx, p, out_idx, run, idle;
        bit seen;
        last_addr = '0; last_rd = '0; idx = 0; out_idx = 0;
        run = 0; idle = 0; seen = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                last_addr = '0; last_rd = '0; idx = 0;
                ca = '0; bus_s = 1'b0;
            end else begin
                for (int d = 0; d < 8; d++)
                    ca[d] = present[d] & avail[d * 4 + int'(last_addr)];
                if (last_rd != '0) begin
                    p = dev_of(last_rd) * 4 + int'(last_addr);
                    if (idx == 0) begin
                        served_cnt++;
                        if (!avail[p] || !present[p / 4]) unexp_bad++;
                        if (!first_of_row && rr_next(last_served) != p) order_bad++;
                        if (first_port < 0) first_port = p;
                        first_of_row = 0;
                        last_served = p;
                        cur_port = p;
                        cell_bytes = 0; cell_aborts = 0; cell_eops = 0;
                    end
                    bus_d = byte_of(p, idx);
                    bus_p = ^bus_d;
                    bus_s = soc_of(p, idx);
                    if (idx == 52) avail[p] = 1'b0;
                    idx++;
                end else begin
                    idx = 0;
                    bus_s = 1'b0;
                end
                last_addr = phy_addr;
                last_rd   = phy_rd_en;

                if (cell_valid) begin
                    if (cell_sop) out_idx = 0; else out_idx++;
                    cell_bytes++;
                    if (int'(cell_port) != cur_port) port_bad++;
                    if (cell_data != byte_of(cur_port, out_idx)) data_bad++;
                    if (cell_par != ^cell_data) par_bad++;
                    if (cell_eop) begin
                        cell_eops++;
                        eop_total++;
                        if (out_idx != 52) data_bad++;
                    end
                end
                if (cell_abort) cell_aborts++;

                if (phy_rd_en != '0) begin
                    if ($countones(phy_rd_en) != 1) onehot_bad++;
                    if (run == 0 && seen && idle < gap_min) gap_min = idle;
                    run++;
                    idle = 0;
                end else begin
                    if (run != 0) begin
                        if (run != 53) burst_bad++;
                        seen = 1;
                    end
                    run = 0;
                    idle++;
                end
            end
        end
    end

    task automatic wait_served(input int n);
        int c;
        c = 0;
        while (served_cnt < n && c < 6000) begin
            @(posedge clk); #1;
            c++;
        end
        repeat (120) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", served_cnt, 0);
        summary();
        $finish;
    end

    initial begin
        int m_exp;
        logic [31:0] m_av;
        logic [7:0]  m_pr;
        int expect_eops;
        avail = 32'h0000_0044;   // ports 2 and 6 waiting at reset release
        repeat (4) @(posedge clk);
        #1;
        // R11 reset state
        check(phy_rd_en == '0, "R11", "read-enable in reset", int'(phy_rd_en), 0);
        check(!cell_valid, "R11", "valid in reset", int'(cell_valid), 0);
        check(!cell_abort, "R11", "abort in reset", int'(cell_abort), 0);
        rst = 1'b0;

        wait_served(2);
        // R4: polling begins at port 0, so port 2 precedes port 6
        check(first_port == 2, "R4", "first port after reset", first_port, 2);
        check(served_cnt == 2, "R3", "cells served at reset release", served_cnt, 2);
        expect_eops = 2;

        // Table of stimulus rows
        for (int r = 0; r < 5; r++) begin
            {m_av, m_pr} = VEC[r][47:8];
            m_exp = int'(VEC[r][7:0]);
            present = m_pr;
            first_of_row = 1;
            served_cnt = 0;
            avail = m_av;
            wait_served(m_exp);
            check(served_cnt == m_exp, "R5", $sformatf("cells served row %0d", r),
                  served_cnt, m_exp);
            expect_eops += m_exp;
            avail = '0;
            present = 8'hFF;
        end

        check(order_bad == 0, "R4", "round-robin order violations", order_bad, 0);
        check(unexp_bad == 0, "R3", "ports served without a cell", unexp_bad, 0);
        check(port_bad == 0, "R1", "port number mismatches", port_bad, 0);
        check(data_bad == 0, "R8", "byte content or position errors", data_bad, 0);
        check(par_bad == 0, "R8", "parity mismatches", par_bad, 0);
        check(eop_total == expect_eops, "R8", "complete cells delivered",
              eop_total, expect_eops);
        check(burst_bad == 0, "R6", "bursts not 53 cycles", burst_bad, 0);
        check(onehot_bad == 0, "R2", "multiple read-enables", onehot_bad, 0);
        check(gap_min >= 3, "R7", "smallest idle gap", gap_min, 3);

        // R9: start-of-cell missing on byte 0
        err_port = 9; err_mode = 1;
        first_of_row = 1; served_cnt = 0;
        avail = 32'h1 << 9;
        wait_served(1);
        check(cell_bytes == 0, "R9", "bytes delivered from bad cell", cell_bytes, 0);
        check(cell_aborts == 1, "R9", "abort pulses", cell_aborts, 1);

        // R10: start-of-cell repeated at byte 20
        err_port = 17; err_mode = 2;
        first_of_row = 1; served_cnt = 0;
        avail = 32'h1 << 17;
        wait_served(1);
        check(cell_bytes == 20, "R10", "bytes before mid-cell start", cell_bytes, 20);
        check(cell_aborts == 1, "R10", "abort pulses", cell_aborts, 1);
        check(cell_eops == 0, "R10", "end-of-cell on dropped cell", cell_eops, 0);

        // recovery after framing errors
        err_mode = 0; err_port = -1;
        first_of_row = 1; served_cnt = 0;
        avail = (32'h1 << 17) | (32'h1 << 30);
        wait_served(2);
        check(served_cnt == 2, "R4", "cells served after errors", served_cnt, 2);
        check(cell_eops == 1 && cell_bytes == 53, "R8", "last cell byte count",
              cell_bytes, 53);
        check(data_bad == 0 && port_bad == 0, "R1", "data after recovery",
              data_bad + port_bad, 0);

        summary();
        $finish;
    end
endmodule